// File: doc/BRIEF.md
# Instruction Cycle Issue Sequencer

This block fetches program words and issues instructions for a small core with 16-bit instruction words. It runs on the oscillator clock. It divides that clock into instruction cycles of four phases and marks each phase with a strobe. Each instruction cycle executes one instruction while the next program word is prefetched. The fetch address steps forward by one word per cycle.

A separate decoder watches the words. It feeds back hints:
- whether the incoming word opens a two-word instruction,
- whether the executing instruction changes the program counter,
- whether a conditional skip is true,
- the target address.

A two-word instruction takes two cycles. Its continuation word is issued together with its first word and never executes on its own. When a continuation word (top nibble all ones) is reached by itself, it becomes a NOP cycle.

Either a program-counter change or a true conditional makes the prefetched word stale. The sequencer drops that word and inserts a NOP cycle in its place. A free-running instruction-cycle counter lets the latency of each instruction be measured at the ports.

Top module: `icycle_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are as follows: fetch address 0, phase strobe 0 (bit 0) set, issueKind 0 (NOP), issueNop high, both issue words 0, cycle counter 0.
- R2: The phase strobes are one-hot. Bits 0, 1, 2 and 3 are each high for one clock, in that order. Fetch address, issueKind and issue words change only at the clock edge that ends phase bit 3.
- R3: A plain single-word instruction occupies one instruction cycle. The fetch address advances by one word per cycle, and the fetched word is issued in the next cycle.
- R4: If hintPcChange is high in a cycle with issueKind 1 (single word), the next cycle is a NOP, and it fetches from hintTarget.
- R5: If hintCondTrue is high (and hintPcChange is low) in a cycle with issueKind 1, the next cycle is a NOP and the fetch address still advances by one. The prefetched word is skipped. With hintCondTrue low, no NOP is inserted.
- R6: A word fetched while hintTwoWord is high is issued with issueKind 2 (first half). The following cycle has issueKind 3 (pair complete), with issueWord0 holding the first word and issueWord1 the continuation, whatever that word's top nibble is. Hints are ignored during an issueKind 2 cycle.
- R7: If hintPcChange is high during issueKind 3, the next cycle is a NOP fetching from hintTarget. A taken two-word branch therefore spans three cycles, and an untaken one spans two.
- R8: A word whose bits 15:12 equal 4'hF, reached outside a two-word instruction, gives a NOP cycle with issueWord0 equal to 0.
- R9: All hints are ignored during NOP cycles (issueKind 0), so the fetch address simply advances by one.
- R10: cycleCount increases by exactly one at the end of each instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| progData | input | 16 | Program word read at fetchAddr |
| hintTwoWord | input | 1 | progData opens a two-word instruction |
| hintPcChange | input | 1 | Executing instruction changes the program counter |
| hintCondTrue | input | 1 | Executing conditional skip is true |
| hintTarget | input | AW (8) | New fetch address on a program-counter change |
| phaseStb | output | 4 | One-hot phase strobes |
| fetchAddr | output | AW (8) | Address of the word being prefetched |
| issueWord0 | output | 16 | Issued word, or first word of a pair |
| issueWord1 | output | 16 | Continuation word when issueKind is 3, else 0 |
| issueKind | output | 2 | 0 NOP, 1 single, 2 pair first half, 3 pair complete |
| issueNop | output | 1 | Current cycle is a NOP |
| cycleCount | output | CW (16) | Instruction cycles since reset |

## Verification
One short program is walked cycle by cycle. It contains:
- plain words,
- a single-word jump,
- a true skip and a false skip,
- an untaken and a taken two-word branch,
- a stray continuation word.

Comparing fetch address, issue kind and cycle count in each cycle separates the one-, two- and three-cycle latencies. The program is then rerun with hints forced active in every NOP and first-half cycle. An identical trace shows those hints are ignored, while a jump to the forced address would expose a leak. Directed runs step through the four phases of one cycle to check strobe order and output stability, and apply reset in the middle of a cycle.

// File: rtl/icycle_pkg.sv
package icycle_pkg;

  // Issue kind presented each instruction cycle
  typedef enum logic [1:0] {
    KIND_NOP  = 2'd0,
    KIND_ONE  = 2'd1,
    KIND_HEAD = 2'd2,
    KIND_PAIR = 2'd3
  } kind_e;

  // Strobes from control to datapath, valid on the cycle-ending clock
  typedef struct packed {
    logic advance;  // instruction cycle ends at this edge
    logic loadW0;   // start a new instruction from progData
    logic loadW1;   // capture continuation word
    logic zeroW;    // issue a NOP next cycle
    logic jump;     // fetch from target instead of next word
  } step_t;

  localparam logic [3:0] CONT_NIBBLE = 4'hF;

endpackage

// File: rtl/icycle_ctrl.sv
module icycle_ctrl
  import icycle_pkg::*;
#(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     progTop,
  input  logic           hintTwoWord,
  input  logic           hintPcChange,
  input  logic           hintCondTrue,
  output logic [NPH-1:0] phaseStb,
  output kind_e          kind,
  output step_t          step
);

  localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;

  logic [PW-1:0] phase;
  logic          lastPhase;
  kind_e         nextKind;
  logic          flushReq;

  assign lastPhase = (phase == PW'(NPH - 1));

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (lastPhase) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_stb
    assign phaseStb[g] = (phase == PW'(g));
  end

  // Only a finished instruction (single or completed pair) may flush
  assign flushReq = ((kind == KIND_ONE) || (kind == KIND_PAIR)) &&
                    (hintPcChange || hintCondTrue);

  always_comb begin
    nextKind     = kind;
    step         = '0;
    step.advance = lastPhase;
    if (lastPhase) begin
      if (kind == KIND_HEAD) begin
        nextKind    = KIND_PAIR;
        step.loadW1 = 1'b1;
      end else if (flushReq) begin
        nextKind   = KIND_NOP;
        step.zeroW = 1'b1;
        step.jump  = hintPcChange;
      end else if (progTop == CONT_NIBBLE) begin
        nextKind   = KIND_NOP;
        step.zeroW = 1'b1;
      end else begin
        nextKind    = hintTwoWord ? KIND_HEAD : KIND_ONE;
        step.loadW0 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            kind <= KIND_NOP;
    else if (lastPhase) kind <= nextKind;
  end

endmodule

// File: rtl/icycle_dpath.sv
module icycle_dpath
  import icycle_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 16,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  step_t         step,
  input  logic [W-1:0]  progData,
  input  logic [AW-1:0] hintTarget,
  output logic [AW-1:0] fetchAddr,
  output logic [W-1:0]  issueWord0,
  output logic [W-1:0]  issueWord1,
  output logic [CW-1:0] cycleCount
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchAddr  <= '0;
      cycleCount <= '0;
    end else if (step.advance) begin
      fetchAddr  <= step.jump ? hintTarget : fetchAddr + 1'b1;
      cycleCount <= cycleCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issueWord0 <= '0;
      issueWord1 <= '0;
    end else if (step.loadW0) begin
      issueWord0 <= progData;
      issueWord1 <= '0;
    end else if (step.loadW1) begin
      issueWord1 <= progData;
    end else if (step.zeroW) begin
      issueWord0 <= '0;
      issueWord1 <= '0;
    end
  end

endmodule

// File: rtl/icycle_seq.sv
module icycle_seq
  import icycle_pkg::*;
#(
  parameter int AW  = 8,
  parameter int CW  = 16,
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [15:0]    progData,
  input  logic           hintTwoWord,
  input  logic           hintPcChange,
  input  logic           hintCondTrue,
  input  logic [AW-1:0]  hintTarget,
  output logic [NPH-1:0] phaseStb,
  output logic [AW-1:0]  fetchAddr,
  output logic [15:0]    issueWord0,
  output logic [15:0]    issueWord1,
  output logic [1:0]     issueKind,
  output logic           issueNop,
  output logic [CW-1:0]  cycleCount
);

  step_t stepBus;
  kind_e kindNow;

  icycle_ctrl #(.NPH(NPH)) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .progTop      (progData[15:12]),
    .hintTwoWord  (hintTwoWord),
    .hintPcChange (hintPcChange),
    .hintCondTrue (hintCondTrue),
    .phaseStb     (phaseStb),
    .kind         (kindNow),
    .step         (stepBus)
  );

  icycle_dpath #(.AW(AW), .CW(CW), .W(16)) uDpath (
    .clk        (clk),
    .rst        (rst),
    .step       (stepBus),
    .progData   (progData),
    .hintTarget (hintTarget),
    .fetchAddr  (fetchAddr),
    .issueWord0 (issueWord0),
    .issueWord1 (issueWord1),
    .cycleCount (cycleCount)
  );

  assign issueKind = kindNow;
  assign issueNop  = (kindNow == KIND_NOP);

endmodule

// File: rtl/icycle_seq_chk.sv
module icycle_seq_chk #(
  parameter int AW  = 8,
  parameter int CW  = 16,
  parameter int NPH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [15:0]    progData,
  input logic           hintPcChange,
  input logic           hintCondTrue,
  input logic [AW-1:0]  hintTarget,
  input logic [NPH-1:0] phaseStb,
  input logic [AW-1:0]  fetchAddr,
  input logic [15:0]    issueWord0,
  input logic [15:0]    issueWord1,
  input logic [1:0]     issueKind,
  input logic           issueNop,
  input logic [CW-1:0]  cycleCount
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetchAddr == '0) && issueNop && phaseStb[0] && (cycleCount == '0));

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] |=> phaseStb[0]);

  // R2
  mid_cycle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !phaseStb[NPH-1] |=> $stable(fetchAddr) && $stable(issueKind) && $stable(issueWord0));

  // R4
  pc_change_flush_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && (issueKind == 2'd1) && hintPcChange
      |=> issueNop && (fetchAddr == $past(hintTarget)));

  // R5
  skip_flush_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && (issueKind == 2'd1) && hintCondTrue && !hintPcChange
      |=> issueNop && (fetchAddr == $past(fetchAddr) + 1'b1));

  // R6
  pair_complete_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && (issueKind == 2'd2)
      |=> (issueKind == 2'd3) && (issueWord1 == $past(progData)) &&
          (issueWord0 == $past(issueWord0)));

  // R7
  pair_branch_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && (issueKind == 2'd3) && hintPcChange
      |=> issueNop && (fetchAddr == $past(hintTarget)));

  // R8
  orphan_nop_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && (issueKind != 2'd2) &&
    !(issueKind[0] && (hintPcChange || hintCondTrue)) && (progData[15:12] == 4'hF)
      |=> issueNop && (issueWord0 == 16'h0));

  // R9
  nop_ignores_hints_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] && issueNop |=> fetchAddr == $past(fetchAddr) + 1'b1);

  // R10
  cycle_count_chk: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NPH-1] |=> cycleCount == $past(cycleCount) + 1'b1);

endmodule

bind icycle_seq icycle_seq_chk #(.AW(AW), .CW(CW), .NPH(NPH)) uChk (
  .clk          (clk),
  .rst          (rst),
  .progData     (progData),
  .hintPcChange (hintPcChange),
  .hintCondTrue (hintCondTrue),
  .hintTarget   (hintTarget),
  .phaseStb     (phaseStb),
  .fetchAddr    (fetchAddr),
  .issueWord0   (issueWord0),
  .issueWord1   (issueWord1),
  .issueKind    (issueKind),
  .issueNop     (issueNop),
  .cycleCount   (cycleCount)
);

// File: tb/sim_icycle_seq.sv
`timescale 1ns/1ps
module sim_icycle_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] progData;
  logic        hintTwoWord, hintPcChange, hintCondTrue;
  logic [7:0]  hintTarget;
  logic [3:0]  phaseStb;
  logic [7:0]  fetchAddr;
  logic [15:0] issueWord0, issueWord1;
  logic [1:0]  issueKind;
  logic        issueNop;
  logic [15:0] cycleCount;
  logic        junk = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  icycle_seq u0 (
    .clk(clk), .rst(rst), .progData(progData),
    .hintTwoWord(hintTwoWord), .hintPcChange(hintPcChange),
    .hintCondTrue(hintCondTrue), .hintTarget(hintTarget),
    .phaseStb(phaseStb), .fetchAddr(fetchAddr),
    .issueWord0(issueWord0), .issueWord1(issueWord1),
    .issueKind(issueKind), .issueNop(issueNop), .cycleCount(cycleCount)
  );

  // Test program: 0 plain, 1 plain, 2 jump, E two-word, F continuation
  function automatic logic [15:0] memAt(logic [7:0] a);
    case (a[3:0])
      4'h0: return 16'h0001;  4'h1: return 16'h2005;
      4'h2: return 16'h0BAD;  4'h3: return 16'h1001;
      4'h4: return 16'h0444;  4'h5: return 16'hE000;
      4'h6: return 16'hF009;  4'h7: return 16'hE001;
      4'h8: return 16'hF00C;  4'h9: return 16'h0999;
      4'hA: return 16'h0AAA;  4'hB: return 16'h0BBB;
      4'hC: return 16'hF0CC;  4'hD: return 16'h1000;
      4'hE: return 16'h0EEE;  default: return 16'h2003;
    endcase
  endfunction

  // Bench-side decoder producing the hints
  always_comb begin
    progData     = memAt(fetchAddr);
    hintTwoWord  = (progData[15:12] == 4'hE);
    hintPcChange = ((issueKind == 2'd1) && (issueWord0[15:12] == 4'h2)) ||
                   ((issueKind == 2'd3) && issueWord0[0]);
    hintCondTrue = (issueKind == 2'd1) && (issueWord0[15:12] == 4'h1) && issueWord0[0];
    hintTarget   = (issueKind == 2'd3) ? issueWord1[7:0] : issueWord0[7:0];
    if (junk && ((issueKind == 2'd0) || (issueKind == 2'd2))) begin
      hintPcChange = 1'b1;
      hintCondTrue = 1'b1;
      hintTarget   = 8'h55;
    end
  end

  // Per cycle: {fetchAddr, issueKind, issueWord0, issueWord1}
  localparam logic [41:0] TRACE [16] = '{
    {8'h00, 2'd0, 16'h0000, 16'h0000},
    {8'h01, 2'd1, 16'h0001, 16'h0000},
    {8'h02, 2'd1, 16'h2005, 16'h0000},
    {8'h05, 2'd0, 16'h0000, 16'h0000},
    {8'h06, 2'd2, 16'hE000, 16'h0000},
    {8'h07, 2'd3, 16'hE000, 16'hF009},
    {8'h08, 2'd2, 16'hE001, 16'h0000},
    {8'h09, 2'd3, 16'hE001, 16'hF00C},
    {8'h0C, 2'd0, 16'h0000, 16'h0000},
    {8'h0D, 2'd0, 16'h0000, 16'h0000},
    {8'h0E, 2'd1, 16'h1000, 16'h0000},
    {8'h0F, 2'd1, 16'h0EEE, 16'h0000},
    {8'h10, 2'd1, 16'h2003, 16'h0000},
    {8'h03, 2'd0, 16'h0000, 16'h0000},
    {8'h04, 2'd1, 16'h1001, 16'h0000},
    {8'h05, 2'd0, 16'h0000, 16'h0000}
  };

  function automatic string rowTag(int k);
    case (k)
      0: return "R1";
      1, 11: return "R3";
      2, 3, 12, 13: return "R4";
      4, 5: return "R6";
      6, 7, 8: return "R7";
      9: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(fetchAddr == 8'h00, "R1", "reset fetchAddr", 64'(fetchAddr), 0);
    chk(phaseStb == 4'b0001, "R1", "reset phaseStb", 64'(phaseStb), 1);
    chk(issueNop && issueKind == 2'd0, "R1", "reset issueKind", 64'(issueKind), 0);
    chk(cycleCount == 16'd0, "R1", "reset cycleCount", 64'(cycleCount), 0);
    rst = 1'b0;
  endtask

  task automatic runTrace(string pre);
    doReset();
    for (int k = 0; k < 16; k++) begin
      while (phaseStb != 4'b0001) @(negedge clk);
      chk(fetchAddr == TRACE[k][41:34], {pre, rowTag(k)},
          $sformatf("cycle %0d fetchAddr", k), 64'(fetchAddr), 64'(TRACE[k][41:34]));
      chk(issueKind == TRACE[k][33:32], {pre, rowTag(k)},
          $sformatf("cycle %0d issueKind", k), 64'(issueKind), 64'(TRACE[k][33:32]));
      chk(issueWord0 == TRACE[k][31:16] && issueWord1 == TRACE[k][15:0], {pre, rowTag(k)},
          $sformatf("cycle %0d issue words", k), {32'h0, issueWord0, issueWord1},
          64'(TRACE[k][31:0]));
      chk(issueNop == (TRACE[k][33:32] == 2'd0), {pre, rowTag(k)},
          $sformatf("cycle %0d issueNop", k), 64'(issueNop), 64'(TRACE[k][33:32] == 2'd0));
      chk(cycleCount == 16'(k), "R10", $sformatf("cycle %0d cycleCount", k),
          64'(cycleCount), 64'(k));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  a0;
    logic [1:0]  k0;
    logic [15:0] w0, c0;
    runTrace("");
    junk = 1'b1;
    runTrace("R9/");
    junk = 1'b0;

    // R2: phase order and output stability within one cycle
    while (phaseStb != 4'b0001) @(negedge clk);
    a0 = fetchAddr; k0 = issueKind; w0 = issueWord0; c0 = cycleCount;
    for (int i = 0; i < 4; i++) begin
      chk(phaseStb == 4'(1 << i), "R2", "phase strobe order", 64'(phaseStb), 64'(1 << i));
      chk(fetchAddr == a0 && issueKind == k0 && issueWord0 == w0, "R2",
          "outputs stable in cycle", 64'({fetchAddr, issueKind, issueWord0}),
          64'({a0, k0, w0}));
      @(negedge clk);
    end
    chk(phaseStb == 4'b0001, "R2", "phase wraps", 64'(phaseStb), 1);
    chk(cycleCount == c0 + 16'd1, "R10", "count step", 64'(cycleCount), 64'(c0 + 16'd1));

    // R1: reset in mid cycle
    while (phaseStb != 4'b0100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(fetchAddr == 8'h00 && issueNop, "R1", "mid-cycle reset addr/nop",
        64'({fetchAddr, issueNop}), 64'({8'h00, 1'b1}));
    chk(phaseStb == 4'b0001 && cycleCount == 16'd0, "R1", "mid-cycle reset phase/count",
        64'({phaseStb, cycleCount}), 64'({4'b0001, 16'd0}));
    rst = 1'b0;
    repeat (8) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule